// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This unit watches the 32-bit effective pin vector of the first GPIO bank and turns pin activity into interrupt status. Each bit can be set to one of two detection types. A level-type bit reports while its pin differs from a per-bit polarity bit. An edge-type bit records any change of its pin since the previous clock, in either direction. Edge events are held until software clears them. A mask register selects which raw status bits reach the single interrupt output.

Software uses the same 32-bit register address map as the neighbouring port block. The unit holds an enable register, a mask register, a type register, a polarity register and a debounce register, and provides two read-only status views. Writing ones to the end-of-interrupt register clears the matching raw bits. The enable and debounce registers are stored and read back, but they have no effect on detection. Pins of the other banks are not connected to this unit.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, every register reads zero: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, masked status 0x40, raw status 0x44, debounce 0x48 and end-of-interrupt 0x4C. The interrupt output is low.
- R2: The enable (0x30), mask (0x34), type (0x38), polarity (0x3C) and debounce (0x48) registers read back the last value written. Enable and debounce have no effect on status.
- R3: When type bit i is 0 (level type), raw status bit i equals pin i XOR polarity bit i as sampled at the previous clock edge. It is recomputed on every cycle.
- R4: When type bit i is 1 (edge type), raw status bit i sets at a clock edge where pin i differs from its value at the previous edge, for either rising or falling. It then stays set.
- R5: Writing 1s to 0x4C clears the matching edge-type raw bits at that clock edge. Bits written as 0 are untouched. A level-type bit whose condition still holds stays set. 0x4C always reads zero.
- R6: If an edge event and an end-of-interrupt clear hit the same bit at the same edge, the bit is set afterwards.
- R7: The masked status at 0x40 reads raw status AND the mask register.
- R8: The interrupt output is registered. It is high in a cycle exactly when some masked status bit was set in the previous cycle.
- R9: Writes to 0x40 and 0x44 change nothing. Reads of addresses outside the map return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_vec | input | 32 | Effective pin values of bank 0 |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Pin activity is generated as sparse random toggles while the type, polarity and mask registers are rewritten at random. Under these mixed per-bit types, a level bit that wrongly latches and an edge bit that wrongly tracks the pin produce different results. Directed sequences cover several cases:
- a single rising and falling pin under each polarity, which separates the XOR sense from a plain copy of the pin;
- end-of-interrupt writes on level bits and on edge bits, which show that only edge bits drop;
- a toggle landing in the same cycle as its clear;
- writes aimed at the status addresses;
- the one-cycle delay from status to the interrupt output.

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pin_vec,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_out
);
  localparam logic [AW-1:0] A_EN   = AW'(8'h30);
  localparam logic [AW-1:0] A_MASK = AW'(8'h34);
  localparam logic [AW-1:0] A_TYPE = AW'(8'h38);
  localparam logic [AW-1:0] A_POL  = AW'(8'h3C);
  localparam logic [AW-1:0] A_STAT = AW'(8'h40);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h44);
  localparam logic [AW-1:0] A_DEB  = AW'(8'h48);
  localparam logic [AW-1:0] A_EOI  = AW'(8'h4C);

  logic [W-1:0] en_q, mask_q, type_q, pol_q, deb_q;
  logic [W-1:0] raw_q, prev_q;
  logic         irq_q;

  logic [W-1:0] clr, edge_evt, lvl_cond, raw_d, stat;

  assign clr      = (bus_wr && bus_addr == A_EOI) ? bus_wdata : '0;
  assign edge_evt = (pin_vec ^ prev_q) & type_q;
  assign lvl_cond = (pin_vec ^ pol_q) & ~type_q;
  assign raw_d    = lvl_cond | (type_q & ((raw_q & ~clr) | edge_evt));
  assign stat     = raw_q & mask_q;
  assign irq_out  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      deb_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_EN:    en_q   <= bus_wdata;
        A_MASK:  mask_q <= bus_wdata;
        A_TYPE:  type_q <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_DEB:   deb_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      prev_q <= pin_vec;
      irq_q  <= |stat;
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_MASK:  bus_rdata = mask_q;
      A_TYPE:  bus_rdata = type_q;
      A_POL:   bus_rdata = pol_q;
      A_STAT:  bus_rdata = stat;
      A_RAW:   bus_rdata = raw_q;
      A_DEB:   bus_rdata = deb_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pin_vec,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  raw_q,
  input logic [W-1:0]  prev_q,
  input logic [W-1:0]  type_q,
  input logic [W-1:0]  pol_q,
  input logic [W-1:0]  mask_q,
  input logic          irq_out
);
  a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(type_q)) == (($past(pin_vec) ^ $past(pol_q)) & ~$past(type_q))));

  a_r4_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(pin_vec) ^ $past(prev_q)) & $past(type_q)) & ~raw_q) == '0));

  a_r5_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h4C)) |=>
      ((raw_q & $past(type_q) & $past(bus_wdata) & ~($past(pin_vec) ^ $past(prev_q))) == '0));

  a_r8_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(raw_q & mask_q))));
endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_vec(pin_vec), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .raw_q(raw_q), .prev_q(prev_q),
  .type_q(type_q), .pol_q(pol_q), .mask_q(mask_q), .irq_out(irq_out)
);

// File: tb/sim_pinirq_ctrl.sv
module sim_pinirq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_vec = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_en, m_mask, m_type, m_pol, m_deb, m_raw, m_prev;
  logic        m_irq;

  pinirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pin_vec(pin_vec), .bus_addr(bus_addr),
                  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                  .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h30: return m_en;
      8'h34: return m_mask;
      8'h38: return m_type;
      8'h3C: return m_pol;
      8'h40: return m_raw & m_mask;
      8'h44: return m_raw;
      8'h48: return m_deb;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [7:0] a);
    case (a)
      8'h40: return "R7";
      8'h44: return "R3/R4";
      8'h4C: return "R5";
      8'h30, 8'h34, 8'h38, 8'h3C, 8'h48: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_mask = '0; m_type = '0; m_pol = '0; m_deb = '0;
    m_raw = '0; m_prev = '0; m_irq = 1'b0;
  endtask

  task automatic step(logic [7:0] a, logic w, logic [31:0] d, logic [31:0] p);
    logic [31:0] clr, evt, nraw;
    bus_addr = a; bus_wr = w; bus_wdata = d; pin_vec = p;
    @(posedge clk);
    clr  = (w && a == 8'h4C) ? d : 32'h0;
    evt  = (p ^ m_prev) & m_type;
    nraw = ((p ^ m_pol) & ~m_type) | (m_type & ((m_raw & ~clr) | evt));
    m_irq = |(m_raw & m_mask);
    m_raw = nraw;
    m_prev = p;
    if (w) begin
      case (a)
        8'h30: m_en = d;
        8'h34: m_mask = d;
        8'h38: m_type = d;
        8'h3C: m_pol = d;
        8'h48: m_deb = d;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    chk(read_tag(a), bus_rdata, model_read(a));
    chk("R8", {31'h0, irq_out}, {31'h0, m_irq});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(a, 1'b1, d, pin_vec);
  endtask

  task automatic rd(logic [7:0] a);
    step(a, 1'b0, 32'h0, pin_vec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [9];
    void'($urandom(32'd2718));
    addrs = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h60};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", {31'h0, irq_out}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      bus_addr = 8'h30 + 8'(4 * i);
      #1;
      chk("R1", bus_rdata, 32'h0);
    end

    // R2: readback, enable and debounce do not alter status
    wr(8'h30, 32'hA5A5_0F0F); wr(8'h48, 32'h1234_5678);
    rd(8'h30); chk("R2 en", bus_rdata, 32'hA5A5_0F0F);
    rd(8'h48); chk("R2 deb", bus_rdata, 32'h1234_5678);
    rd(8'h44); chk("R2 no effect", bus_rdata, 32'h0);

    // R3: level with polarity
    wr(8'h34, 32'hFFFF_FFFF);
    step(8'h44, 1'b0, 32'h0, 32'h0000_0001);
    chk("R3 high", bus_rdata, 32'h0000_0001);
    chk("R8 lag", {31'h0, irq_out}, 32'h0);
    rd(8'h40); chk("R8 raised", {31'h0, irq_out}, 32'h1);
    wr(8'h3C, 32'h0000_0001);
    rd(8'h44); chk("R3 pol", bus_rdata, 32'h0);

    // R5: EOI on level bit keeps it; EOI reads zero
    step(8'h44, 1'b0, 32'h0, 32'h0000_0003);
    chk("R5 pre", bus_rdata, 32'h0000_0002);
    wr(8'h4C, 32'h0000_0002);
    rd(8'h44); chk("R5 level stays", bus_rdata, 32'h0000_0002);
    rd(8'h4C); chk("R5 reads zero", bus_rdata, 32'h0);

    // R4: edge both directions, held
    wr(8'h38, 32'h0000_0030);
    step(8'h44, 1'b0, 32'h0, 32'h0000_0013);
    chk("R4 rise", bus_rdata & 32'h30, 32'h10);
    step(8'h44, 1'b0, 32'h0, 32'h0000_0013);
    chk("R4 held", bus_rdata & 32'h30, 32'h10);
    wr(8'h4C, 32'h0000_0010);
    rd(8'h44); chk("R5 edge clr", bus_rdata & 32'h30, 32'h0);
    step(8'h44, 1'b0, 32'h0, 32'h0000_0003);
    chk("R4 fall", bus_rdata & 32'h30, 32'h10);

    // R6: collision
    step(8'h4C, 1'b1, 32'h0000_0030, 32'h0000_0023);
    rd(8'h44); chk("R6 edge wins", bus_rdata & 32'h30, 32'h20);

    // R9: status writes ignored, unmapped reads zero
    wr(8'h44, 32'h0); wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h44); chk("R9 raw kept", bus_rdata & 32'h30, 32'h20);
    wr(8'h60, 32'hDEAD_BEEF);
    rd(8'h60); chk("R9 unmapped", bus_rdata, 32'h0);

    // R7: partial mask
    wr(8'h34, 32'h0000_0020);
    rd(8'h40); chk("R7 masked", bus_rdata, 32'h0000_0020);

    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] p;
      logic [7:0]  a;
      p = pin_vec ^ ($urandom & $urandom & $urandom);
      a = addrs[$urandom_range(8)];
      if ($urandom_range(9) < 3) begin
        logic [31:0] d;
        d = $urandom;
        if (a == 8'h4C && $urandom_range(1) == 1) d = 32'hFFFF_FFFF;
        step(a, 1'b1, d, p);
      end else begin
        step(a, 1'b0, 32'h0, p);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule